// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block produces the address of a load or store micro-operation in one registered step. The offset is the sum of a scaled index, a base and a signed displacement. It is cut down to the active address width, which is 2, 4 or 8 bytes. For a normal memory access, the segment base is then added to the cut-down offset, which gives the linear address. For an address-only operation, such as load-effective-address, the cut-down offset itself is the result and the segment base plays no part.

The active width normally comes from the instruction's address size. An operation that implicitly uses the stack takes its width from the stack size instead, so an address-size override on the instruction cannot change how a stack access wraps. An unsupported scale or width raises an error flag, and the address is forced to zero. Checking the segment limit and translating the address are left to later stages.

A two-state controller paces the result. The controller is in IDLE or EMIT. The transition IDLE→EMIT and the transition EMIT→EMIT are taken on a cycle with `in_valid` high. The transition EMIT→IDLE and the transition IDLE→IDLE are taken on a cycle with `in_valid` low. `out_valid` is high only in EMIT.

Top module: `seg_eaddr_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid`, `out_err` and `out_addr` are all zero.
- R2: `out_valid` is high in exactly those cycles that follow a cycle with `in_valid` high, so the latency is one clock edge and back-to-back requests are accepted.
- R3: The offset is `scale*index + base + disp`, computed modulo 2^64. It is then truncated to its low `8*size` bits, where size is the selected width in bytes (2, 4 or 8).
- R4: When `addr_only` is 0, `out_addr` equals the truncated offset plus `seg_base`, modulo 2^64. The segment base is added after truncation.
- R5: When `addr_only` is 1, `out_addr` equals the truncated offset, and `seg_base` has no effect.
- R6: When `implicit_stack` is 1, the width is taken from `stack_size` and `addr_size` is ignored. An out-of-range `addr_size` then raises no error.
- R7: `scale` is a byte count that must be 1, 2, 4 or 8. Any other value sets `out_err` and forces `out_addr` to 0.
- R8: The selected width, `addr_size` or `stack_size`, is a byte count that must be 2, 4 or 8. Any other value sets `out_err` and forces `out_addr` to 0.
- R9: In any cycle where `out_valid` is low, `out_addr` and `out_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| scale | input | 4 | Index multiplier as a byte count (1, 2, 4, 8) |
| index | input | 64 | Index register value |
| base | input | 64 | Base register value |
| disp | input | 64 | Sign-extended displacement |
| seg_base | input | 64 | Segment base address |
| addr_size | input | 4 | Instruction address width in bytes |
| stack_size | input | 4 | Stack address width in bytes |
| implicit_stack | input | 1 | Take the width from `stack_size` |
| addr_only | input | 1 | Return the offset without the segment base |
| out_valid | output | 1 | Result valid |
| out_addr | output | 64 | Linear address, or offset in address-only mode |
| out_err | output | 1 | Unsupported scale or width |

## Verification
The bench builds 16-bit and 32-bit offsets that carry past the width. A design that adds the segment base before truncating would then clip the segment base away. A design that truncates after adding it would lose the high bits of the base. A negative displacement that wraps below zero is checked against a segment base above 4 GiB, and stack accesses are given an address size that disagrees with the stack size, so taking the width from the wrong field shows up as a wrong wrap or a spurious error. Address-only requests carry a non-zero segment base, which exposes a design that adds it anyway. Idle gaps between back-to-back requests catch a stuck or early `out_valid` and stale outputs.

// File: rtl/eag_pkg.sv
package eag_pkg;
    // Controller states of the address generator
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } eag_state_e;

    // Number of supported address widths: 2, 4 and 8 bytes
    localparam int EAG_NUM_SIZES = 3;
endpackage

// File: rtl/eag_offset.sv
module eag_offset #(
    parameter int AW = 64,
    parameter int SW = 4
) (
    input  logic [SW-1:0] scale,
    input  logic [AW-1:0] index,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] disp,
    output logic [AW-1:0] offset,
    output logic          scale_ok
);
    logic [AW-1:0] scaled;

    // The scale is a power of two, so multiplying by it is a left shift.
    always_comb begin
        scaled   = '0;
        scale_ok = 1'b1;
        unique case (scale)
            SW'(1):  scaled = index;
            SW'(2):  scaled = index << 1;
            SW'(4):  scaled = index << 2;
            SW'(8):  scaled = index << 3;
            default: scale_ok = 1'b0;
        endcase
    end

    // Carries out of bit AW-1 are dropped.
    assign offset = scaled + base + disp;
endmodule

// File: rtl/eag_trunc.sv
module eag_trunc
    import eag_pkg::*;
#(
    parameter int AW = 64,
    parameter int SW = 4
) (
    input  logic [AW-1:0] offset,
    input  logic [SW-1:0] size,
    output logic [AW-1:0] trunc,
    output logic          size_ok
);
    logic [AW-1:0] cand [EAG_NUM_SIZES];

    // One candidate for each supported width: 2 << k bytes.
    for (genvar k = 0; k < EAG_NUM_SIZES; k++) begin : g_width
        localparam int NBITS = 8 * (2 << k);
        if (NBITS >= AW) begin : g_full
            assign cand[k] = offset;
        end else begin : g_cut
            assign cand[k] = {{(AW-NBITS){1'b0}}, offset[NBITS-1:0]};
        end
    end

    always_comb begin
        trunc   = '0;
        size_ok = 1'b0;
        for (int i = 0; i < EAG_NUM_SIZES; i++) begin
            if (size == SW'(2 << i)) begin
                trunc   = cand[i];
                size_ok = 1'b1;
            end
        end
    end
endmodule

// File: rtl/seg_eaddr_gen.sv
module seg_eaddr_gen
    import eag_pkg::*;
#(
    parameter int AW = 64,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [SW-1:0] scale,
    input  logic [AW-1:0] index,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] disp,
    input  logic [AW-1:0] seg_base,
    input  logic [SW-1:0] addr_size,
    input  logic [SW-1:0] stack_size,
    input  logic          implicit_stack,
    input  logic          addr_only,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output logic          out_err
);
    eag_state_e    state_q, state_d;
    logic [SW-1:0] eff_size;
    logic [AW-1:0] raw_off, cut_off, lin_addr;
    logic          scale_ok, size_ok, bad;
    logic [AW-1:0] addr_q;
    logic          err_q;

    // Stack accesses ignore the instruction's address size.
    assign eff_size = implicit_stack ? stack_size : addr_size;

    eag_offset #(.AW(AW), .SW(SW)) u_off (
        .scale    (scale),
        .index    (index),
        .base     (base),
        .disp     (disp),
        .offset   (raw_off),
        .scale_ok (scale_ok)
    );

    eag_trunc #(.AW(AW), .SW(SW)) u_trn (
        .offset  (raw_off),
        .size    (eff_size),
        .trunc   (cut_off),
        .size_ok (size_ok)
    );

    // The segment base is added after truncation, and never in address-only mode.
    assign lin_addr = addr_only ? cut_off : cut_off + seg_base;
    assign bad      = !(scale_ok && size_ok);

    // Next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            err_q  <= 1'b0;
        end else if (in_valid) begin
            addr_q <= bad ? '0 : lin_addr;
            err_q  <= bad;
        end else begin
            addr_q <= '0;
            err_q  <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_EMIT);
    assign out_addr  = addr_q;
    assign out_err   = err_q;
endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
    parameter int AW = 64,
    parameter int SW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [SW-1:0] scale,
    input logic [SW-1:0] addr_size,
    input logic [SW-1:0] stack_size,
    input logic          implicit_stack,
    input logic          addr_only,
    input logic          out_valid,
    input logic [AW-1:0] out_addr,
    input logic          out_err
);
    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_addr == '0 && !out_err)); // R9
    AST_ERR_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_addr == '0)); // R7
    AST_BAD_SCALE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !(scale == SW'(1) || scale == SW'(2) || scale == SW'(4) || scale == SW'(8))
        |=> out_err); // R7
    AST_STACK_WIDTH_OK: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && implicit_stack && scale == SW'(1) && stack_size == SW'(8)
        |=> !out_err); // R6
    AST_NARROW_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && addr_only && !implicit_stack && addr_size == SW'(2)
        |=> (out_addr[AW-1:16] == '0)); // R5
endmodule

bind seg_eaddr_gen eag_checker #(.AW(AW), .SW(SW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .scale          (scale),
    .addr_size      (addr_size),
    .stack_size     (stack_size),
    .implicit_stack (implicit_stack),
    .addr_only      (addr_only),
    .out_valid      (out_valid),
    .out_addr       (out_addr),
    .out_err        (out_err)
);

// File: tb/sim_seg_eaddr_gen.sv
`timescale 1ns/1ps
module sim_seg_eaddr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  scale = 4'd1;
    logic [63:0] index = '0, base = '0, disp = '0, seg_base = '0;
    logic [3:0]  addr_size = 4'd8, stack_size = 4'd8;
    logic        implicit_stack = 1'b0, addr_only = 1'b0;
    logic        out_valid, out_err;
    logic [63:0] out_addr;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic        exp_v, exp_e;
    logic [63:0] exp_a;
    string       exp_tag;

    always #2 clk = ~clk;

    seg_eaddr_gen u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .scale(scale),
        .index(index), .base(base), .disp(disp), .seg_base(seg_base),
        .addr_size(addr_size), .stack_size(stack_size),
        .implicit_stack(implicit_stack), .addr_only(addr_only),
        .out_valid(out_valid), .out_addr(out_addr), .out_err(out_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model: behaviour written from the requirements.
    task automatic model(output logic [63:0] a, output logic e);
        int sz;
        longint unsigned off;
        bit sok, zok;
        sz  = implicit_stack ? int'(stack_size) : int'(addr_size);
        sok = (scale == 1 || scale == 2 || scale == 4 || scale == 8);
        zok = (sz == 2 || sz == 4 || sz == 8);
        if (!sok || !zok) begin
            a = '0; e = 1'b1;
        end else begin
            off = index * longint'(scale) + base + disp;
            if (sz < 8) off = off & ((64'd1 << (sz * 8)) - 64'd1);
            a = addr_only ? off : off + seg_base;
            e = 1'b0;
        end
    endtask

    // Advance one cycle and compare all outputs against the model.
    task automatic adv();
        @(negedge clk);
        chk("R2 valid", {63'd0, out_valid}, {63'd0, exp_v});
        chk(exp_tag, out_addr, exp_a);
        chk({exp_tag, " err"}, {63'd0, out_err}, {63'd0, exp_e});
    endtask

    task automatic req(input logic [3:0] sc, input logic [63:0] ix, input logic [63:0] bs,
                       input logic [63:0] ds, input logic [63:0] sg, input logic [3:0] asz,
                       input logic [3:0] ssz, input logic stk, input logic ao, input string tag);
        in_valid = 1'b1; scale = sc; index = ix; base = bs; disp = ds; seg_base = sg;
        addr_size = asz; stack_size = ssz; implicit_stack = stk; addr_only = ao;
        exp_v = 1'b1; exp_tag = tag;
        model(exp_a, exp_e);
        adv();
    endtask

    task automatic idle();
        in_valid = 1'b0;
        seg_base = 64'hFFFF_0000_1234_0000;
        exp_v = 1'b0; exp_a = '0; exp_e = 1'b0; exp_tag = "R9 idle";
        adv();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid", {63'd0, out_valid}, 64'd0);
        chk("R1 addr", out_addr, 64'd0);
        chk("R1 err", {63'd0, out_err}, 64'd0);
        rst_n = 1'b1;
        idle();
        // R3 plain 64-bit sum
        req(4'd4, 64'h10, 64'h1000, 64'd8, 64'd0, 4'd8, 4'd8, 1'b0, 1'b0, "R3 sum");
        // R3/R4 16-bit carry dropped, then segment added
        req(4'd1, 64'd0, 64'hFFFF, 64'd2, 64'h100, 4'd2, 4'd8, 1'b0, 1'b0, "R4 trunc16+seg");
        // R4 negative displacement wraps in 32 bits, segment above 4 GiB
        req(4'd2, 64'd0, 64'h10, -64'sd32, 64'h1_0000_0000, 4'd4, 4'd8, 1'b0, 1'b0, "R4 wrap32+seg");
        // R3 64-bit overflow discarded
        req(4'd8, 64'hF000_0000_0000_0001, 64'h10, 64'd0, 64'd0, 4'd8, 4'd8, 1'b0, 1'b0, "R3 wrap64");
        idle();
        // R5 address-only ignores segment base
        req(4'd2, 64'h8000_0001, 64'h1, 64'd0, 64'hDEAD_0000, 4'd4, 4'd8, 1'b0, 1'b1, "R5 addr-only32");
        req(4'd1, 64'h0, 64'h1234_5678, 64'd0, 64'h7777, 4'd2, 4'd8, 1'b0, 1'b1, "R5 addr-only16");
        // R6 stack width overrides address size
        req(4'd1, 64'h0, 64'h1_2345_6789, 64'd0, 64'h10, 4'd2, 4'd8, 1'b1, 1'b0, "R6 stack wide");
        req(4'd1, 64'h0, 64'h1_2345_6789, 64'd0, 64'h10, 4'd8, 4'd2, 1'b1, 1'b0, "R6 stack narrow");
        req(4'd1, 64'h0, 64'h1_FFFF_FFFC, 64'd8, 64'h0, 4'd3, 4'd4, 1'b1, 1'b0, "R6 bad asz ignored");
        idle();
        idle();
        // R7 illegal scales
        req(4'd3, 64'h5, 64'h5, 64'd0, 64'h100, 4'd8, 4'd8, 1'b0, 1'b0, "R7 scale3");
        req(4'd0, 64'h5, 64'h5, 64'd0, 64'h100, 4'd8, 4'd8, 1'b0, 1'b0, "R7 scale0");
        req(4'd8, 64'h5, 64'h5, 64'd0, 64'h100, 4'd8, 4'd8, 1'b0, 1'b0, "R7 scale8 ok");
        // R8 illegal widths
        req(4'd1, 64'h5, 64'h5, 64'd0, 64'h100, 4'd3, 4'd8, 1'b0, 1'b0, "R8 asz3");
        req(4'd1, 64'h5, 64'h5, 64'd0, 64'h100, 4'd8, 4'd0, 1'b1, 1'b0, "R8 ssz0");
        req(4'd1, 64'h5, 64'h5, 64'd0, 64'h100, 4'd1, 4'd8, 1'b0, 1'b1, "R8 asz1");
        idle();
        // Mixed back-to-back run
        for (int i = 0; i < 24; i++) begin
            req(4'd1 << (i % 4), 64'h0123_4567_89AB_CDEF * (i + 1), 64'hFFFF_FFF0 + i,
                64'd0 - i * 7, 64'h4000_0000 * i, 4'd2 << (i % 3), 4'd2 << ((i + 1) % 3),
                (i % 5) == 0, (i % 3) == 1, "R3 mixed");
            if (i % 7 == 6) idle();
        end
        idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule